// File: doc/BRIEF.md
# CEC Receive Destination Filter

This block sits behind the bit-level receiver of a CEC-style serial bus node. When the header byte of an incoming message has been assembled, the receiver pulses a valid strobe and the filter decides, for the rest of that message, three things. It decides whether the frame is taken into the receive buffer. It decides whether this node drives a positive acknowledge. It decides whether the remaining bytes are dropped. It also flags broadcast traffic.

The node's identity is a claim mask. Each set bit marks one logical address that the node answers to, so a single node can hold several addresses at once. A listening-mode input selects between two behaviours. In selective mode, the node keeps only traffic for its claimed addresses and broadcasts. In promiscuous mode, it also keeps frames for other nodes, but does not acknowledge them. The decision is registered and held until the receiver signals end of message or abort.

Top module: `cec_rx_dest_filter`

## Requirements
- R1: After reset, accept_o, ack_en_o, bcast_o and drop_o are all 0.
- R2: The destination is header bits 3:0. The destination is a claimed address when claim_mask_i bit [destination] is 1, for destinations 0 to 14. Any number of mask bits may be set at once.
- R3: In selective mode (promisc_i = 0), a header to a claimed address gives accept_o = 1, ack_en_o = 1, drop_o = 0 and bcast_o = 0.
- R4: In selective mode, a header to an unclaimed, non-broadcast address gives accept_o = 0, ack_en_o = 0 and drop_o = 1.
- R5: Destination 15 is broadcast. It gives accept_o = 1, bcast_o = 1, ack_en_o = 0 and drop_o = 0 in both modes, whatever the mask holds.
- R6: In promiscuous mode (promisc_i = 1), a header to an unclaimed address gives accept_o = 1, ack_en_o = 0 and drop_o = 0.
- R7: In promiscuous mode, a header to a claimed address gives accept_o = 1 and ack_en_o = 1.
- R8: The outputs take the new decision on the clock edge that samples hdr_valid_i = 1. They hold it while neither a strobe nor a clear arrives.
- R9: msg_end_i or msg_abort_i drives all outputs to 0 on the next edge. A clear wins over a header strobe in the same cycle.
- R10: Header bits 7:4 have no effect on the decision.
- R11: Changes to claim_mask_i or promisc_i after a header has been latched do not alter the held decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| claim_mask_i | input | 15 | One bit per claimed logical address |
| promisc_i | input | 1 | 1 = promiscuous listening, 0 = selective |
| hdr_byte_i | input | 8 | Received header byte |
| hdr_valid_i | input | 1 | Header byte valid strobe |
| msg_end_i | input | 1 | End of current message |
| msg_abort_i | input | 1 | Current message aborted |
| accept_o | output | 1 | Frame goes to the receive buffer |
| ack_en_o | output | 1 | Node drives positive acknowledge |
| bcast_o | output | 1 | Current message is broadcast |
| drop_o | output | 1 | Remaining bytes are ignored |

## Verification
On every cycle, the checker watches the invariants between the outputs:
- an acknowledge is never enabled without acceptance or on a broadcast;
- a broadcast is always accepted;
- accept and drop never coincide;
- the outputs stay stable between events;
- a clear empties the decision;
- a promiscuous-mode header is always accepted.

Only the directed scenarios can show which address a header actually resolves to:
- multi-bit masks and the broadcast index;
- the selective drop case;
- that the initiator nibble and later mask or mode changes leave a held decision alone.

// File: rtl/cec_filt_pkg.sv
package cec_filt_pkg;
  // Per-message decision carried from the policy stage to the hold register.
  typedef struct packed {
    logic accept;
    logic ack_en;
    logic bcast;
    logic drop;
  } filt_dec_t;
endpackage

// File: rtl/cec_dest_decode.sv
module cec_dest_decode #(
  parameter int DEST_W = 4,
  parameter int HDR_W  = 8,
  localparam int OWN_W = (1 << DEST_W) - 1
) (
  input  logic [HDR_W-1:0] hdr_byte_i,
  input  logic [OWN_W-1:0] claim_mask_i,
  output logic             claimed_o,
  output logic             bcast_o
);
  localparam logic [DEST_W-1:0] BCAST_ADDR = {DEST_W{1'b1}};

  logic [DEST_W-1:0] dest;
  logic [OWN_W-1:0]  hit_vec;

  assign dest = hdr_byte_i[DEST_W-1:0];

  // One comparator per claimable address; the broadcast index has no mask bit.
  for (genvar g = 0; g < OWN_W; g++) begin : g_hit
    assign hit_vec[g] = claim_mask_i[g] && (dest == DEST_W'(g));
  end

  assign claimed_o = |hit_vec;
  assign bcast_o   = (dest == BCAST_ADDR);
endmodule

// File: rtl/cec_filt_policy.sv
module cec_filt_policy
  import cec_filt_pkg::*;
(
  input  logic      claimed_i,
  input  logic      bcast_i,
  input  logic      promisc_i,
  output filt_dec_t dec_o
);
  always_comb begin
    dec_o        = '0;
    dec_o.bcast  = bcast_i;
    // Broadcast acknowledge polarity is inverted on the bus, so never drive it.
    dec_o.ack_en = claimed_i && !bcast_i;
    dec_o.accept = claimed_i || bcast_i || promisc_i;
    dec_o.drop   = !dec_o.accept;
  end
endmodule

// File: rtl/cec_filt_hold.sv
module cec_filt_hold
  import cec_filt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  logic      clear_i,
  input  filt_dec_t dec_i,
  output filt_dec_t dec_q_o
);
  filt_dec_t dec_q, dec_d;

  always_comb begin
    dec_d = dec_q;
    if (clear_i)     dec_d = '0;
    else if (load_i) dec_d = dec_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_q <= '0;
    else        dec_q <= dec_d;
  end

  assign dec_q_o = dec_q;
endmodule

// File: rtl/cec_rx_dest_filter.sv
module cec_rx_dest_filter
  import cec_filt_pkg::*;
#(
  parameter int DEST_W = 4,
  parameter int HDR_W  = 8,
  localparam int OWN_W = (1 << DEST_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OWN_W-1:0] claim_mask_i,
  input  logic             promisc_i,
  input  logic [HDR_W-1:0] hdr_byte_i,
  input  logic             hdr_valid_i,
  input  logic             msg_end_i,
  input  logic             msg_abort_i,
  output logic             accept_o,
  output logic             ack_en_o,
  output logic             bcast_o,
  output logic             drop_o
);
  logic      claimed, is_bcast;
  filt_dec_t dec_now, dec_held;

  cec_dest_decode #(.DEST_W(DEST_W), .HDR_W(HDR_W)) u_decode (
    .hdr_byte_i   (hdr_byte_i),
    .claim_mask_i (claim_mask_i),
    .claimed_o    (claimed),
    .bcast_o      (is_bcast)
  );

  cec_filt_policy u_policy (
    .claimed_i (claimed),
    .bcast_i   (is_bcast),
    .promisc_i (promisc_i),
    .dec_o     (dec_now)
  );

  cec_filt_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (hdr_valid_i),
    .clear_i (msg_end_i | msg_abort_i),
    .dec_i   (dec_now),
    .dec_q_o (dec_held)
  );

  assign accept_o = dec_held.accept;
  assign ack_en_o = dec_held.ack_en;
  assign bcast_o  = dec_held.bcast;
  assign drop_o   = dec_held.drop;
endmodule

// File: rtl/cec_rx_dest_filter_chk.sv
module cec_rx_dest_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic promisc_i,
  input logic hdr_valid_i,
  input logic msg_end_i,
  input logic msg_abort_i,
  input logic accept_o,
  input logic ack_en_o,
  input logic bcast_o,
  input logic drop_o
);
  assert_ack_needs_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en_o |-> accept_o);

  assert_bcast_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_o |-> (accept_o && !ack_en_o));

  assert_drop_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_o && drop_o));

  assert_promisc_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid_i && !msg_end_i && !msg_abort_i && promisc_i) |=> accept_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_valid_i && !msg_end_i && !msg_abort_i)
      |=> $stable({accept_o, ack_en_o, bcast_o, drop_o}));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_end_i || msg_abort_i) |=> !(accept_o || ack_en_o || bcast_o || drop_o));
endmodule

bind cec_rx_dest_filter cec_rx_dest_filter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .promisc_i   (promisc_i),
  .hdr_valid_i (hdr_valid_i),
  .msg_end_i   (msg_end_i),
  .msg_abort_i (msg_abort_i),
  .accept_o    (accept_o),
  .ack_en_o    (ack_en_o),
  .bcast_o     (bcast_o),
  .drop_o      (drop_o)
);

// File: tb/cec_rx_dest_filter_tb.sv
module cec_rx_dest_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [14:0] claim_mask;
  logic        promisc;
  logic [7:0]  hdr_byte;
  logic        hdr_valid, msg_end, msg_abort;
  logic        accept, ack_en, bcast, drop;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  cec_rx_dest_filter dut_i (
    .clk (clk), .rst_n (rst_n), .claim_mask_i (claim_mask), .promisc_i (promisc),
    .hdr_byte_i (hdr_byte), .hdr_valid_i (hdr_valid), .msg_end_i (msg_end),
    .msg_abort_i (msg_abort), .accept_o (accept), .ack_en_o (ack_en),
    .bcast_o (bcast), .drop_o (drop)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Compare {accept, ack_en, bcast, drop} against the expected value.
  task automatic expect_out(input logic [3:0] exp, input string req);
    n_checks++;
    if ({accept, ack_en, bcast, drop} !== exp) begin
      n_fail++;
      $display("FAIL %s: got acc/ack/bc/drop=%b expected %b",
               req, {accept, ack_en, bcast, drop}, exp);
    end
  endtask

  // Drive one header strobe at a falling edge; the result is visible one cycle later.
  task automatic send_hdr(input logic [7:0] hb, input logic [14:0] m, input logic p);
    claim_mask = m; promisc = p; hdr_byte = hb; hdr_valid = 1;
    @(negedge clk);
    hdr_valid = 0;
  endtask

  task automatic end_msg();
    msg_end = 1;
    @(negedge clk);
    msg_end = 0;
  endtask

  task automatic t_reset();
    expect_out(4'b0000, "R1 reset");
  endtask

  task automatic t_selective();
    send_hdr(8'h03, 15'h0008, 0); expect_out(4'b1100, "R3 claimed dest 3");
    end_msg();
    send_hdr(8'h05, 15'h0008, 0); expect_out(4'b0001, "R4 unclaimed dest 5");
    end_msg();
    // R2: several claimed addresses at once, including top index 14
    send_hdr(8'h0E, 15'h4011, 0); expect_out(4'b1100, "R2 multi claim dest 14");
    send_hdr(8'h04, 15'h4011, 0); expect_out(4'b1100, "R2 multi claim dest 4");
    send_hdr(8'h01, 15'h4011, 0); expect_out(4'b0001, "R2 multi claim dest 1 unclaimed");
    end_msg();
  endtask

  task automatic t_broadcast();
    send_hdr(8'h0F, 15'h7FFF, 0); expect_out(4'b1010, "R5 bcast selective full mask");
    end_msg();
    send_hdr(8'h2F, 15'h0000, 1); expect_out(4'b1010, "R5 bcast promisc empty mask");
    end_msg();
  endtask

  task automatic t_promisc();
    send_hdr(8'h07, 15'h0001, 1); expect_out(4'b1000, "R6 promisc other dest");
    end_msg();
    send_hdr(8'h00, 15'h0001, 1); expect_out(4'b1100, "R7 promisc own dest");
    end_msg();
  endtask

  task automatic t_hold_and_clear();
    send_hdr(8'h02, 15'h0004, 0);
    repeat (3) @(negedge clk);
    expect_out(4'b1100, "R8 held over idle cycles");
    // R11: mask and mode changes after latch are ignored
    claim_mask = 15'h0000; promisc = 1; hdr_byte = 8'h09;
    @(negedge clk);
    expect_out(4'b1100, "R11 held after mask/mode change");
    msg_abort = 1; @(negedge clk); msg_abort = 0;
    expect_out(4'b0000, "R9 abort clears");
    // Clear wins over a simultaneous header strobe
    claim_mask = 15'h0004; promisc = 0; hdr_byte = 8'h02;
    hdr_valid = 1; msg_end = 1;
    @(negedge clk);
    hdr_valid = 0; msg_end = 0;
    expect_out(4'b0000, "R9 clear beats strobe");
  endtask

  task automatic t_initiator_bits();
    send_hdr(8'hA3, 15'h0008, 0); expect_out(4'b1100, "R10 initiator A dest 3");
    send_hdr(8'h35, 15'h0008, 0); expect_out(4'b0001, "R10 initiator 3 dest 5");
    end_msg();
  endtask

  initial begin
    rst_n = 0; claim_mask = '0; promisc = 0; hdr_byte = '0;
    hdr_valid = 0; msg_end = 0; msg_abort = 0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_selective();
    t_broadcast();
    t_promisc();
    t_hold_and_clear();
    t_initiator_bits();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule